// File: doc/BRIEF.md
# Request/Response Channel Contract Monitor

This block watches, without driving anything, a request/response channel that carries an 8-bit payload in each direction. It checks two kinds of promise. The first is how long a payload must stay stable. A request payload is held until the matching response has been taken. A response payload is held for the one cycle after it has been taken. The second is the timing pattern each message follows. Each end of each message can be declared dynamic (it uses a handshake wire), fixed at one cycle (it is ready again one cycle after its previous transfer), or, for the response only, locked at a fixed cycle offset from the request (no response handshake wires at all).

Parameters pick the pattern per message. The monitor works out from each pattern which wires define a transfer, then flags four violation classes: request lifetime, response lifetime, schedule, and ordering. Each class drives a combinational pulse in the cycle the fault is visible on the channel. Each class also has a sticky flag that reset alone clears. Pattern combinations that are not well formed stop elaboration.

Top module: `chan_contract_mon`

## Requirements
- R1: After a synchronous active-high reset, all four sticky flags and all four pulse outputs are 0. Bit positions in both vectors: 0 request lifetime, 1 response lifetime, 2 schedule, 3 ordering.
- R2: A message is offered when its valid input is 1. It transfers when offered and either its ack input is 1 (receiver dynamic) or always (receiver fixed). A response in fixed-offset mode transfers exactly N cycles after a request transfer (N=0: the same cycle), and its valid and ack inputs have no effect on any output.
- R3: Each request transfer captures the request payload. From the next cycle up to and including the cycle of the closing response transfer, a request payload different from the captured one raises bit 0. A response transferring in the same cycle as its request closes it at once.
- R4: In the cycle after a response transfer, a response payload different from the transferred one raises bit 1, unless another response transfers in that cycle.
- R5: For a message whose sender is fixed at one cycle, no offer in the cycle after one of its transfers raises bit 2. A dynamic sender is never checked for schedule.
- R6: A request transfer while an earlier request is still open and no response transfers in that cycle raises bit 3.
- R7: Pulses are combinational in the cycle the fault is present. A pulse sets the matching sticky bit at the next clock edge, and the bit then stays 1 until reset.
- R8: Well-formed sender/receiver pattern pairs are: dynamic/dynamic, fixed-1/dynamic, dynamic/fixed-1, fixed-1/fixed-1, and, for the response only, offset-N/offset-N with equal N from 0 to 8. Any other pair fails elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offer seen on the channel |
| req_ack | input | 1 | Request acceptance seen on the channel |
| req_data | input | 8 | Request payload |
| rsp_valid | input | 1 | Response offer seen on the channel |
| rsp_ack | input | 1 | Response acceptance seen on the channel |
| rsp_data | input | 8 | Response payload |
| err_pulse | output | 4 | One-cycle violation indication per class |
| err_sticky | output | 4 | Latched violation flags per class |

## Verification
The bench builds two instances. The first keeps every parameter at its default, so both messages are fully dynamic; this reaches the lifetime and ordering rules and shows that the schedule rule stays silent. The second declares the request sender fixed at one cycle with a dynamic receiver, and the response at offset 0. It is swept over every 4-cycle acceptance stall pattern, which reaches the schedule rule, the same-cycle response and the back-to-back response exemption, while showing that the response handshake wires are ignored. The legality function is swept over every kind and count from 0 to 2 on both sides, with and without offset permission.

// File: rtl/chan_mon_pkg.sv
`timescale 1ns/1ps
package chan_mon_pkg;

    typedef enum logic [1:0] {
        SK_DYN = 2'd0,
        SK_CYC = 2'd1,
        SK_REL = 2'd2
    } side_kind_e;

    localparam int ERR_REQ_LIFE = 0;
    localparam int ERR_RSP_LIFE = 1;
    localparam int ERR_SCHED    = 2;
    localparam int ERR_ORDER    = 3;
    localparam int NUM_ERR      = 4;
    localparam int REL_MAX      = 8;

    typedef logic [NUM_ERR-1:0] err_vec_t;

    typedef struct packed {
        logic offer;
        logic xfer;
    } msg_evt_t;

    function automatic bit pattern_ok(side_kind_e snd, int snd_n,
                                      side_kind_e rcv, int rcv_n,
                                      bit rel_allowed);
        if (snd == SK_DYN && rcv == SK_DYN) return 1'b1;
        if (snd == SK_CYC && rcv == SK_DYN) return snd_n == 1;
        if (snd == SK_DYN && rcv == SK_CYC) return rcv_n == 1;
        if (snd == SK_CYC && rcv == SK_CYC) return (snd_n == 1) && (rcv_n == 1);
        if (snd == SK_REL && rcv == SK_REL)
            return rel_allowed && (snd_n == rcv_n) && (snd_n >= 0) && (snd_n <= REL_MAX);
        return 1'b0;
    endfunction

endpackage

// File: rtl/ccm_msg_xfer.sv
`timescale 1ns/1ps
module ccm_msg_xfer
    import chan_mon_pkg::*;
#(
    parameter side_kind_e SND_KIND = SK_DYN,
    parameter side_kind_e RCV_KIND = SK_DYN,
    parameter int         REL_N    = 0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     valid,
    input  logic     ack,
    input  logic     anchor_xfer,
    output msg_evt_t evt
);

    generate
        if (SND_KIND == SK_REL) begin : g_rel
            logic unused_hs;
            assign unused_hs = valid ^ ack;
            if (REL_N == 0) begin : g_same
                logic unused_clk;
                assign unused_clk = clk ^ rst;
                assign evt.offer  = anchor_xfer;
                assign evt.xfer   = anchor_xfer;
            end else begin : g_dly
                logic [REL_N-1:0] dly;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        dly <= '0;
                    end else begin
                        dly[0] <= anchor_xfer;
                        for (int i = 1; i < REL_N; i++) dly[i] <= dly[i-1];
                    end
                end
                assign evt.offer = dly[REL_N-1];
                assign evt.xfer  = dly[REL_N-1];
            end
        end else begin : g_hs
            logic unused_t;
            logic accept;
            assign unused_t  = clk ^ rst ^ anchor_xfer;
            assign accept    = (RCV_KIND == SK_DYN) ? ack : 1'b1;
            assign evt.offer = valid;
            assign evt.xfer  = valid & accept;
        end
    endgenerate

endmodule

// File: rtl/ccm_sched_chk.sv
`timescale 1ns/1ps
module ccm_sched_chk
    import chan_mon_pkg::*;
#(
    parameter bit ENABLE = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  msg_evt_t evt,
    output logic     viol
);

    generate
        if (ENABLE) begin : g_on
            logic last_xfer;
            always_ff @(posedge clk) begin
                if (rst) last_xfer <= 1'b0;
                else     last_xfer <= evt.xfer;
            end
            assign viol = last_xfer & ~evt.offer;
        end else begin : g_off
            logic unused_s;
            assign unused_s = ^{clk, rst, evt};
            assign viol     = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/ccm_life_trk.sv
`timescale 1ns/1ps
module ccm_life_trk
    import chan_mon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  msg_evt_t          req_evt,
    input  msg_evt_t          rsp_evt,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              req_armed,
    output logic              req_life_viol,
    output logic              rsp_life_viol,
    output logic              order_viol
);

    logic [DATA_W-1:0] req_held;
    logic [DATA_W-1:0] rsp_held;
    logic              rsp_watch;
    logic              armed_nxt;

    // request window: opens on request transfer, closes on response transfer
    always_comb begin
        if (req_evt.xfer) armed_nxt = req_armed | ~rsp_evt.xfer;
        else              armed_nxt = req_armed & ~rsp_evt.xfer;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_armed <= 1'b0;
            req_held  <= '0;
            rsp_watch <= 1'b0;
            rsp_held  <= '0;
        end else begin
            req_armed <= armed_nxt;
            if (req_evt.xfer) req_held <= req_data;
            rsp_watch <= rsp_evt.xfer;
            if (rsp_evt.xfer) rsp_held <= rsp_data;
        end
    end

    assign req_life_viol = req_armed & (req_data != req_held);
    assign order_viol    = req_armed & req_evt.xfer & ~rsp_evt.xfer;
    assign rsp_life_viol = rsp_watch & ~rsp_evt.xfer & (rsp_data != rsp_held);

endmodule

// File: rtl/chan_contract_mon.sv
`timescale 1ns/1ps
module chan_contract_mon
    import chan_mon_pkg::*;
#(
    parameter int         DATA_W       = 8,
    parameter side_kind_e REQ_SND_KIND = SK_DYN,
    parameter int         REQ_SND_N    = 0,
    parameter side_kind_e REQ_RCV_KIND = SK_DYN,
    parameter int         REQ_RCV_N    = 0,
    parameter side_kind_e RSP_SND_KIND = SK_DYN,
    parameter int         RSP_SND_N    = 0,
    parameter side_kind_e RSP_RCV_KIND = SK_DYN,
    parameter int         RSP_RCV_N    = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_ack,
    input  logic [DATA_W-1:0] req_data,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    input  logic [DATA_W-1:0] rsp_data,
    output logic [NUM_ERR-1:0] err_pulse,
    output logic [NUM_ERR-1:0] err_sticky
);

    localparam bit REQ_OK    = pattern_ok(REQ_SND_KIND, REQ_SND_N, REQ_RCV_KIND, REQ_RCV_N, 1'b0);
    localparam bit RSP_OK    = pattern_ok(RSP_SND_KIND, RSP_SND_N, RSP_RCV_KIND, RSP_RCV_N, 1'b1);
    localparam bit REQ_FIXED = (REQ_SND_KIND == SK_CYC);
    localparam bit RSP_FIXED = (RSP_SND_KIND == SK_CYC);

    generate
        if (!REQ_OK) begin : g_bad_req
            $error("chan_contract_mon: request synchronization pattern is ill-formed");
        end
        if (!RSP_OK) begin : g_bad_rsp
            $error("chan_contract_mon: response synchronization pattern is ill-formed");
        end
    endgenerate

    msg_evt_t req_evt;
    msg_evt_t rsp_evt;
    logic     req_armed;
    logic     req_life_v, rsp_life_v, order_v;
    logic     req_sched_v, rsp_sched_v;
    err_vec_t pulse_c;

    ccm_msg_xfer #(
        .SND_KIND(REQ_SND_KIND), .RCV_KIND(REQ_RCV_KIND), .REL_N(0)
    ) u_req_xfer (
        .clk(clk), .rst(rst), .valid(req_valid), .ack(req_ack),
        .anchor_xfer(1'b0), .evt(req_evt)
    );

    ccm_msg_xfer #(
        .SND_KIND(RSP_SND_KIND), .RCV_KIND(RSP_RCV_KIND), .REL_N(RSP_SND_N)
    ) u_rsp_xfer (
        .clk(clk), .rst(rst), .valid(rsp_valid), .ack(rsp_ack),
        .anchor_xfer(req_evt.xfer), .evt(rsp_evt)
    );

    ccm_sched_chk #(.ENABLE(REQ_FIXED)) u_req_sched (
        .clk(clk), .rst(rst), .evt(req_evt), .viol(req_sched_v)
    );

    ccm_sched_chk #(.ENABLE(RSP_FIXED)) u_rsp_sched (
        .clk(clk), .rst(rst), .evt(rsp_evt), .viol(rsp_sched_v)
    );

    ccm_life_trk #(.DATA_W(DATA_W)) u_life (
        .clk(clk), .rst(rst), .req_evt(req_evt), .rsp_evt(rsp_evt),
        .req_data(req_data), .rsp_data(rsp_data), .req_armed(req_armed),
        .req_life_viol(req_life_v), .rsp_life_viol(rsp_life_v),
        .order_viol(order_v)
    );

    always_comb begin
        pulse_c               = '0;
        pulse_c[ERR_REQ_LIFE] = req_life_v;
        pulse_c[ERR_RSP_LIFE] = rsp_life_v;
        pulse_c[ERR_SCHED]    = req_sched_v | rsp_sched_v;
        pulse_c[ERR_ORDER]    = order_v;
    end

    assign err_pulse = pulse_c;

    always_ff @(posedge clk) begin
        if (rst) err_sticky <= '0;
        else     err_sticky <= err_sticky | pulse_c;
    end

endmodule

// File: rtl/ccm_checker.sv
`timescale 1ns/1ps
module ccm_checker
    import chan_mon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [DATA_W-1:0]  rsp_data,
    input logic [NUM_ERR-1:0] err_pulse,
    input logic [NUM_ERR-1:0] err_sticky,
    input logic               req_xfer,
    input logic               rsp_xfer,
    input logic               req_armed
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ERR; gi++) begin : g_bit
            a_r7_pulse_sets_sticky: assert property (@(posedge clk) disable iff (rst)
                err_pulse[gi] |=> err_sticky[gi]);
            a_r7_sticky_holds: assert property (@(posedge clk) disable iff (rst)
                err_sticky[gi] |=> err_sticky[gi]);
            a_r7_sticky_has_cause: assert property (@(posedge clk) disable iff (rst)
                $rose(err_sticky[gi]) |-> $past(err_pulse[gi]));
        end
    endgenerate

    a_r6_order_flagged: assert property (@(posedge clk) disable iff (rst)
        (req_xfer && req_armed && !rsp_xfer) |-> err_pulse[ERR_ORDER]);

    a_r3_window_opens: assert property (@(posedge clk) disable iff (rst)
        (req_xfer && !rsp_xfer) |=> req_armed);

    a_r4_rsp_hold: assert property (@(posedge clk) disable iff (rst)
        rsp_xfer |=> (rsp_xfer || (rsp_data == $past(rsp_data)) || err_pulse[ERR_RSP_LIFE]));

    a_r3_no_life_pulse_idle: assert property (@(posedge clk) disable iff (rst)
        !req_armed |-> !err_pulse[ERR_REQ_LIFE]);

endmodule

bind chan_contract_mon ccm_checker #(.DATA_W(DATA_W)) u_ccm_chk (
    .clk(clk), .rst(rst), .rsp_data(rsp_data),
    .err_pulse(err_pulse), .err_sticky(err_sticky),
    .req_xfer(req_evt.xfer), .rsp_xfer(rsp_evt.xfer), .req_armed(req_armed)
);

// File: tb/chan_contract_mon_bench.sv
`timescale 1ns/1ps
module chan_contract_mon_bench;
    import chan_mon_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // instance with all-dynamic defaults
    logic       a_rv, a_rk, a_pv, a_pk;
    logic [7:0] a_rd, a_pd;
    logic [3:0] a_pulse, a_sticky;

    // instance: request sender fixed-1 / receiver dynamic, response at offset 0
    logic       b_rv, b_rk, b_pv, b_pk;
    logic [7:0] b_rd, b_pd;
    logic [3:0] b_pulse, b_sticky;

    chan_contract_mon u_chan_contract_mon (
        .clk(clk), .rst(rst),
        .req_valid(a_rv), .req_ack(a_rk), .req_data(a_rd),
        .rsp_valid(a_pv), .rsp_ack(a_pk), .rsp_data(a_pd),
        .err_pulse(a_pulse), .err_sticky(a_sticky)
    );

    chan_contract_mon #(
        .REQ_SND_KIND(SK_CYC), .REQ_SND_N(1),
        .REQ_RCV_KIND(SK_DYN), .REQ_RCV_N(0),
        .RSP_SND_KIND(SK_REL), .RSP_SND_N(0),
        .RSP_RCV_KIND(SK_REL), .RSP_RCV_N(0)
    ) u_chan_contract_mon_sync (
        .clk(clk), .rst(rst),
        .req_valid(b_rv), .req_ack(b_rk), .req_data(b_rd),
        .rsp_valid(b_pv), .rsp_ack(b_pk), .rsp_data(b_pd),
        .err_pulse(b_pulse), .err_sticky(b_sticky)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic do_reset();
        @(posedge clk); #2;
        rst = 1'b1;
        a_rv = 0; a_rk = 0; a_rd = 0; a_pv = 0; a_pk = 0; a_pd = 0;
        b_rv = 0; b_rk = 0; b_rd = 0; b_pv = 0; b_pk = 0; b_pd = 0;
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
        #4;
    endtask

    task automatic step_a(input logic v, input logic k, input logic [7:0] d,
                          input logic pv, input logic pk, input logic [7:0] pd);
        @(posedge clk); #2;
        a_rv = v; a_rk = k; a_rd = d; a_pv = pv; a_pk = pk; a_pd = pd;
        #4;
    endtask

    task automatic step_b(input logic v, input logic k, input logic [7:0] d,
                          input logic pv, input logic pk, input logic [7:0] pd);
        @(posedge clk); #2;
        b_rv = v; b_rk = k; b_rd = d; b_pv = pv; b_pk = pk; b_pd = pd;
        #4;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] cnt;
        logic [7:0] d;

        do_reset();
        // R1 reset state
        chk("R1 sticky A", a_sticky, 4'h0);
        chk("R1 pulse A",  a_pulse,  4'h0);
        chk("R1 sticky B", b_sticky, 4'h0);
        chk("R1 pulse B",  b_pulse,  4'h0);

        // R3/R4/R5 clean transactions, dynamic sender never schedule-checked
        for (int k = 0; k < 16; k++) begin
            d = 8'(k * 17);
            step_a(1, 1, d, 0, 0, 8'h00);
            chk("R3 clean req xfer", a_pulse, 4'h0);
            step_a(0, 0, d, 1, 1, ~d);
            chk("R5 dyn sender no schedule", a_pulse, 4'h0);
            step_a(0, 0, d + 8'd1, 0, 0, ~d);
            chk("R4 clean rsp hold", a_pulse, 4'h0);
        end
        step_a(0, 0, 8'h00, 0, 0, 8'h00);
        chk("R5 sticky stays clear A", a_sticky, 4'h0);

        // R3 request lifetime violation, R7 sticky behaviour
        do_reset();
        step_a(1, 1, 8'h3C, 0, 0, 8'h00);
        step_a(0, 0, 8'h3D, 0, 0, 8'h00);
        chk("R3 req change in window", a_pulse, 4'h1);
        step_a(0, 0, 8'h3C, 1, 1, 8'hAA);
        chk("R3 restored at close", a_pulse, 4'h0);
        chk("R7 sticky set after pulse", a_sticky, 4'h1);
        step_a(0, 0, 8'h77, 0, 0, 8'hAA);
        chk("R3 window closed", a_pulse, 4'h0);
        repeat (3) step_a(0, 0, 8'h00, 0, 0, 8'h00);
        chk("R7 sticky held", a_sticky, 4'h1);
        do_reset();
        chk("R7 sticky cleared by reset", a_sticky, 4'h0);

        // R4 response lifetime violation
        step_a(1, 1, 8'h10, 0, 0, 8'h00);
        step_a(0, 0, 8'h10, 1, 1, 8'h55);
        step_a(0, 0, 8'h10, 0, 0, 8'h56);
        chk("R4 rsp change after xfer", a_pulse, 4'h2);

        // R4 exemption for back-to-back response
        do_reset();
        step_a(1, 1, 8'h20, 0, 0, 8'h00);
        step_a(0, 0, 8'h20, 1, 1, 8'h60);
        step_a(0, 0, 8'h20, 1, 1, 8'h61);
        chk("R4 back-to-back exempt", a_pulse, 4'h0);
        step_a(0, 0, 8'h20, 0, 0, 8'h61);
        chk("R4 second rsp held", a_sticky, 4'h0);

        // R6 ordering
        do_reset();
        step_a(1, 1, 8'h40, 0, 0, 8'h00);
        step_a(1, 1, 8'h40, 0, 0, 8'h00);
        chk("R6 second req while open", a_pulse, 4'h8);
        step_a(0, 0, 8'h40, 1, 1, 8'h00);
        chk("R6 closing rsp clean", a_pulse, 4'h0);

        // R2 ack without valid does not transfer
        do_reset();
        step_a(0, 1, 8'h11, 0, 0, 8'h00);
        step_a(0, 0, 8'h12, 0, 0, 8'h00);
        chk("R2 ack alone no xfer", a_pulse, 4'h0);

        // B: every 4-cycle stall pattern, continuous offer, same-cycle response
        do_reset();
        cnt = 8'h00;
        for (int m = 0; m < 16; m++) begin
            for (int j = 0; j < 4; j++) begin
                logic ak;
                ak = m[j];
                if (ak) cnt = cnt + 8'd1;
                step_b(1, ak, 8'(m * 4 + j), logic'(j[0] ^ m[0]), logic'(j[1]), cnt);
                chk("R2 R4 R5 stall sweep", b_pulse, 4'h0);
            end
        end
        chk("R2 sweep sticky clear", b_sticky, 4'h0);

        // R5 schedule violation
        do_reset();
        step_b(1, 1, 8'h01, 0, 0, 8'h05);
        step_b(0, 0, 8'h01, 0, 0, 8'h05);
        chk("R5 missing offer", b_pulse, 4'h4);
        step_b(0, 0, 8'h01, 0, 0, 8'h05);
        chk("R5 sticky", b_sticky, 4'h4);

        // R4 in offset-0 mode, stall cycle after transfer
        do_reset();
        step_b(1, 1, 8'h02, 0, 0, 8'h09);
        step_b(1, 0, 8'h02, 0, 0, 8'h0A);
        chk("R4 offset rsp change", b_pulse, 4'h2);

        // R2 response wires ignored in offset mode
        do_reset();
        for (int j = 0; j < 6; j++) begin
            step_b(0, 0, 8'h00, 1, 1, 8'(j * 37));
            chk("R2 rsp wires ignored", b_pulse, 4'h0);
        end
        chk("R2 ignored sticky", b_sticky, 4'h0);

        // R8 pattern legality sweep
        for (int s = 0; s < 3; s++)
            for (int sn = 0; sn < 3; sn++)
                for (int r = 0; r < 3; r++)
                    for (int rn = 0; rn < 3; rn++)
                        for (int rel = 0; rel < 2; rel++) begin
                            bit e;
                            e = (s == 0 && r == 0) ||
                                (s == 1 && r == 0 && sn == 1) ||
                                (s == 0 && r == 1 && rn == 1) ||
                                (s == 1 && r == 1 && sn == 1 && rn == 1) ||
                                (s == 2 && r == 2 && rel == 1 && sn == rn);
                            chk("R8 legality",
                                32'(pattern_ok(side_kind_e'(s[1:0]), sn,
                                               side_kind_e'(r[1:0]), rn, rel[0])),
                                32'(e));
                        end

        summary();
        $finish;
    end

endmodule